// File: doc/BRIEF.md
# Flash Status Polling Bit Generator

This block builds the status bits a flash device presents on its data lines while an embedded program or erase engine is busy, suspended, or has ended in failure. A read arriving in those states is answered with status rather than array contents: a data-polling bit, two toggle bits that flip on successive reads, a sticky error bit and an erase-start window bit. When status is not due, a bypass flag tells the read path to return array data.

The operation mode, a per-block mask of blocks under erase, the block addressed by each read and a one-cycle read strobe come from the surrounding command logic. Operation end is signalled by a done pulse with a pass flag, illegal 0-to-1 writes by a separate pulse, and the Read/Reset command by a clear pulse. The erase-start wait is a clock-cycle counter restarted by the last block-erase command. The block locates the faulty block after a failure so that polling software can find it through the second toggle bit.

Top module: `flash_status_gen`

## Requirements
- R1: `mode_i` encodes 0 idle, 1 program, 2 block erase, 3 chip erase, 4 erase suspend, 5 suspend-program; 6 and 7 act as idle. In modes 1, 2, 3 and 5, `dq6_o` inverts after each cycle in which `rd_stb_i` is high; without a read it holds.
- R2: In mode 4 with the read block set in `erase_mask_i`, `dq7_o` and `dq6_o` read 1, `bypass_o` is 0, and reads do not change the later DQ6 value.
- R3: In mode 4 with the read block clear in `erase_mask_i`, `bypass_o` is 1.
- R4: In modes 2, 4 and 5, `dq2_o` shows a toggle flop that inverts on each read of a block set in `erase_mask_i`; a read of a block clear in the mask shows 1 and leaves the flop unchanged.
- R5: In mode 3, `dq2_o` shows the toggle flop and every read inverts it, whatever the block.
- R6: In mode 1, `dq2_o` reads 1 and reads leave the DQ2 flop unchanged.
- R7: `dq7_o` is the inverse of `data7_i` in modes 1 and 5, and 0 in modes 2, 3 and idle.
- R8: A cycle with `done_i` high and `pass_i` low, or with `bad_write_i` high, sets `dq5_o` from the next cycle and records `op_blk_i` as the faulty block.
- R9: `reset_cmd_i` clears `dq5_o` from the next cycle and wins over a simultaneous failure; `done_i` with `pass_i` high also clears it.
- R10: In idle with `dq5_o` set, `bypass_o` is 0 and `dq2_o` toggles on reads of the faulty block only, reading 1 for other blocks.
- R11: After a cycle with `erase_cmd_i` high, `dq3_o` reads 0 for exactly `WIN_CYCLES` cycles, then 1; a new command restarts the count.
- R12: After reset `dq6_o` and `dq5_o` are 0, `dq3_o` is 1 and, in idle, `bypass_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Current operation mode |
| erase_mask_i | input | NUM_BLOCKS | Blocks selected for erase or suspended |
| rd_blk_i | input | $clog2(NUM_BLOCKS) | Block addressed by the current read |
| rd_stb_i | input | 1 | One-cycle read pulse |
| data7_i | input | 1 | Bit 7 of the data being programmed |
| done_i | input | 1 | Operation end pulse |
| pass_i | input | 1 | Operation result, 1 = success |
| bad_write_i | input | 1 | Attempt to write 1 over a programmed 0 |
| reset_cmd_i | input | 1 | Read/Reset command pulse |
| op_blk_i | input | $clog2(NUM_BLOCKS) | Block of the ending or faulting operation |
| erase_cmd_i | input | 1 | Last block-erase command accepted |
| dq7_o | output | 1 | Data-polling bit |
| dq6_o | output | 1 | Read toggle bit |
| dq5_o | output | 1 | Error bit |
| dq3_o | output | 1 | Erase-start window bit, 0 while waiting |
| dq2_o | output | 1 | Block-selective toggle bit |
| bypass_o | output | 1 | Return array data instead of status |

## Verification
The assertions assume that `mode_i`, `rd_blk_i` and `erase_mask_i` stay steady across each read pulse and the cycle after it, so a toggle can be tied to the mode in force when it happened. The bench changes those inputs only on falling edges between reads and holds them while a strobe is high. Event pulses are one cycle wide and never overlap a read, so the error and window checks see one cause at a time except in the deliberate reset-versus-failure case.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE   = 3'd0,
    MODE_PROG   = 3'd1,
    MODE_BERASE = 3'd2,
    MODE_CERASE = 3'd3,
    MODE_ESUSP  = 3'd4,
    MODE_SPROG  = 3'd5
  } fs_mode_e;

  function automatic logic fs_busy(input logic [2:0] m);
    return (m == MODE_PROG) || (m == MODE_BERASE) ||
           (m == MODE_CERASE) || (m == MODE_SPROG);
  endfunction
endpackage

// File: rtl/fs_toggle_pair.sv
module fs_toggle_pair (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_stb_i,
  input  logic en6_i,
  input  logic en2_i,
  output logic t6_o,
  output logic t2_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t6_o <= 1'b0;
      t2_o <= 1'b0;
    end else if (rd_stb_i) begin
      if (en6_i) t6_o <= ~t6_o;
      if (en2_i) t2_o <= ~t2_o;
    end
  end
endmodule

// File: rtl/fs_err_track.sv
module fs_err_track #(
  parameter int BLK_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              pass_i,
  input  logic              bad_write_i,
  input  logic              reset_cmd_i,
  input  logic [BLK_AW-1:0] op_blk_i,
  output logic              err_o,
  output logic [BLK_AW-1:0] fault_blk_o
);
  logic fail;
  assign fail = (done_i && !pass_i) || bad_write_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      fault_blk_o <= '0;
    end else if (reset_cmd_i) begin
      err_o <= 1'b0;
    end else if (fail) begin
      err_o       <= 1'b1;
      fault_blk_o <= op_blk_i;
    end else if (done_i && pass_i) begin
      err_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fs_erase_window.sv
module fs_erase_window #(
  parameter int WIN_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic erase_cmd_i,
  output logic open_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(WIN_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (erase_cmd_i)     cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  // window still counting -> DQ3 low
  assign open_o = (cnt_q == '0);
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int WIN_CYCLES = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [2:0]                    mode_i,
  input  logic [NUM_BLOCKS-1:0]         erase_mask_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] rd_blk_i,
  input  logic                          rd_stb_i,
  input  logic                          data7_i,
  input  logic                          done_i,
  input  logic                          pass_i,
  input  logic                          bad_write_i,
  input  logic                          reset_cmd_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] op_blk_i,
  input  logic                          erase_cmd_i,
  output logic                          dq7_o,
  output logic                          dq6_o,
  output logic                          dq5_o,
  output logic                          dq3_o,
  output logic                          dq2_o,
  output logic                          bypass_o
);
  localparam int BLK_AW = $clog2(NUM_BLOCKS);

  logic              t6, t2, en6, en2, err;
  logic [BLK_AW-1:0] fault_blk;
  logic              blk_hit, fault_hit;

  fs_toggle_pair u_tog (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_stb_i (rd_stb_i),
    .en6_i    (en6),
    .en2_i    (en2),
    .t6_o     (t6),
    .t2_o     (t2)
  );

  fs_err_track #(.BLK_AW(BLK_AW)) u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done_i),
    .pass_i      (pass_i),
    .bad_write_i (bad_write_i),
    .reset_cmd_i (reset_cmd_i),
    .op_blk_i    (op_blk_i),
    .err_o       (err),
    .fault_blk_o (fault_blk)
  );

  fs_erase_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .erase_cmd_i (erase_cmd_i),
    .open_o      (dq3_o)
  );

  assign blk_hit   = erase_mask_i[rd_blk_i];
  assign fault_hit = err && (rd_blk_i == fault_blk);
  assign dq5_o     = err;

  always_comb begin
    en6      = fs_busy(mode_i);
    en2      = 1'b0;
    dq7_o    = 1'b0;
    dq6_o    = t6;
    dq2_o    = 1'b1;
    bypass_o = 1'b0;
    unique case (mode_i)
      MODE_PROG: dq7_o = ~data7_i;
      MODE_BERASE: begin
        en2   = blk_hit;
        dq2_o = blk_hit ? t2 : 1'b1;
      end
      MODE_CERASE: begin
        en2   = 1'b1;
        dq2_o = t2;
      end
      MODE_ESUSP: begin
        en2 = blk_hit;
        if (blk_hit) begin
          dq7_o = 1'b1;
          dq6_o = 1'b1;
          dq2_o = t2;
        end else begin
          bypass_o = 1'b1;
        end
      end
      MODE_SPROG: begin
        en2   = blk_hit;
        dq7_o = ~data7_i;
        dq2_o = blk_hit ? t2 : 1'b1;
      end
      default: begin
        // idle: status persists only to locate a faulty block
        en2      = fault_hit;
        dq2_o    = fault_hit ? t2 : 1'b1;
        bypass_o = ~err;
      end
    endcase
  end
endmodule

// File: rtl/fs_checker.sv
module fs_checker
  import flash_status_pkg::*;
#(
  parameter int NUM_BLOCKS = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [2:0]                    mode_i,
  input logic [NUM_BLOCKS-1:0]         erase_mask_i,
  input logic [$clog2(NUM_BLOCKS)-1:0] rd_blk_i,
  input logic                          rd_stb_i,
  input logic                          data7_i,
  input logic                          done_i,
  input logic                          pass_i,
  input logic                          bad_write_i,
  input logic                          reset_cmd_i,
  input logic                          erase_cmd_i,
  input logic                          dq7_o,
  input logic                          dq6_o,
  input logic                          dq5_o,
  input logic                          dq3_o,
  input logic                          dq2_o,
  input logic                          bypass_o
);
  AST_PROG_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && mode_i == MODE_PROG) |=> (mode_i != MODE_PROG) || (dq6_o != $past(dq6_o))); // R1
  AST_ESUSP_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ESUSP && erase_mask_i[rd_blk_i]) |-> (dq7_o && dq6_o && !bypass_o)); // R2
  AST_ESUSP_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ESUSP && !erase_mask_i[rd_blk_i]) |-> bypass_o); // R3
  AST_PROG_DQ2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PROG) |-> dq2_o); // R6
  AST_PROG_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PROG) |-> (dq7_o != data7_i)); // R7
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((done_i && !pass_i) || bad_write_i) && !reset_cmd_i) |=> dq5_o); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_cmd_i |=> !dq5_o); // R9
  AST_WIN_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_cmd_i |=> !dq3_o); // R11
  AST_IDLE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_IDLE && !dq5_o) |-> bypass_o); // R12
endmodule

bind flash_status_gen fs_checker #(.NUM_BLOCKS(NUM_BLOCKS)) u_fs_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .erase_mask_i(erase_mask_i),
  .rd_blk_i(rd_blk_i), .rd_stb_i(rd_stb_i), .data7_i(data7_i), .done_i(done_i),
  .pass_i(pass_i), .bad_write_i(bad_write_i), .reset_cmd_i(reset_cmd_i),
  .erase_cmd_i(erase_cmd_i), .dq7_o(dq7_o), .dq6_o(dq6_o), .dq5_o(dq5_o),
  .dq3_o(dq3_o), .dq2_o(dq2_o), .bypass_o(bypass_o)
);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 8;
  localparam int AW  = 3;
  localparam int WIN = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [NB-1:0] mask = '0;
  logic [AW-1:0] rblk = '0, oblk = '0;
  logic rd = 0, d7 = 0, done = 0, pass = 0, badw = 0, rcmd = 0, ecmd = 0;
  logic dq7, dq6, dq5, dq3, dq2, byp;

  int n_chk = 0, n_bad = 0;
  bit m_t6 = 0, m_t2 = 0, m_err = 0;
  int m_fblk = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.NUM_BLOCKS(NB), .WIN_CYCLES(WIN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .erase_mask_i(mask),
    .rd_blk_i(rblk), .rd_stb_i(rd), .data7_i(d7), .done_i(done), .pass_i(pass),
    .bad_write_i(badw), .reset_cmd_i(rcmd), .op_blk_i(oblk), .erase_cmd_i(ecmd),
    .dq7_o(dq7), .dq6_o(dq6), .dq5_o(dq5), .dq3_o(dq3), .dq2_o(dq2), .bypass_o(byp)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d blk=%0d act=%0b exp=%0b", tag, mode, rblk, act, exp);
    end
  endtask

  function automatic bit is_busy(input int m);
    return m == 1 || m == 2 || m == 3 || m == 5;
  endfunction

  // check all status outputs against the requirement model, then issue one read
  task automatic read_blk(input int b);
    bit hit, fhit, e7, e6, e2, eb, t2en;
    int m;
    @(negedge clk);
    rblk = AW'(b);
    #1;
    m = (mode > 5) ? 0 : int'(mode);
    hit = mask[b];
    fhit = m_err && (b == m_fblk);
    e6 = m_t6; e2 = 1; eb = 0; e7 = 0; t2en = 0;
    case (m)
      1: e7 = ~d7;
      2: begin t2en = hit; e2 = hit ? m_t2 : 1; end
      3: begin t2en = 1; e2 = m_t2; end
      4: begin t2en = hit; if (hit) begin e7 = 1; e6 = 1; e2 = m_t2; end else eb = 1; end
      5: begin e7 = ~d7; t2en = hit; e2 = hit ? m_t2 : 1; end
      default: begin t2en = fhit; e2 = fhit ? m_t2 : 1; eb = !m_err; end
    endcase
    check(byp, eb, (m == 4) ? "R3" : (m == 0 ? "R12" : "R10"));
    if (!eb) begin
      check(dq7, e7, (m == 4) ? "R2" : "R7");
      check(dq6, e6, (m == 4) ? "R2" : "R1");
      check(dq2, e2, (m == 3) ? "R5" : (m == 1) ? "R6" : (m == 0) ? "R10" : "R4");
    end
    check(dq5, m_err, "R8");
    rd = 1;
    @(negedge clk);
    rd = 0;
    if (is_busy(m)) m_t6 = ~m_t6;
    if (t2en) m_t2 = ~m_t2;
  endtask

  task automatic pulse_evt(input bit dn, input bit ps, input bit bw, input bit rc, input int b);
    @(negedge clk);
    done = dn; pass = ps; badw = bw; rcmd = rc; oblk = AW'(b);
    @(negedge clk);
    done = 0; pass = 0; badw = 0; rcmd = 0;
    if (rc) m_err = 0;
    else if ((dn && !ps) || bw) begin m_err = 1; m_fblk = b; end
    else if (dn && ps) m_err = 0;
    #1;
    check(dq5, m_err, rc ? "R9" : "R8");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NB-1:0] masks [3];
    masks[0] = 8'hA5; masks[1] = 8'h00; masks[2] = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    check(dq6, 0, "R12"); check(dq5, 0, "R12"); check(dq3, 1, "R12"); check(byp, 1, "R12");
    rst_n = 1;

    // sweep modes x masks x blocks, two passes with different data bit
    for (int p = 0; p < 2; p++)
      for (int mi = 0; mi < 8; mi++)
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          mode = 3'(mi); mask = masks[k]; d7 = p[0];
          for (int b = 0; b < NB; b++) read_blk(b);
        end

    // R2: suspended-block reads must not disturb DQ6 seen after return to program
    @(negedge clk); mode = 3'd4; mask = 8'hFF;
    for (int b = 0; b < 4; b++) read_blk(b);
    @(negedge clk); mode = 3'd1; #1;
    check(dq6, m_t6, "R2");

    // error set via failure, faulty block locator in idle
    @(negedge clk); mode = 3'd0; mask = '0;
    pulse_evt(1, 0, 0, 0, 5);
    for (int r = 0; r < 2; r++) for (int b = 0; b < NB; b++) read_blk(b);
    pulse_evt(1, 1, 0, 0, 0);                 // R9 pass clears
    for (int b = 0; b < NB; b++) read_blk(b);
    pulse_evt(0, 0, 1, 0, 2);                 // R8 bad write
    for (int b = 0; b < NB; b++) read_blk(b);
    pulse_evt(0, 0, 0, 1, 0);                 // R9 reset command
    pulse_evt(1, 0, 0, 1, 6);                 // R9 reset wins over failure
    pulse_evt(0, 0, 1, 0, 7);
    for (int b = 0; b < NB; b++) read_blk(b);
    pulse_evt(0, 0, 0, 1, 0);

    // R11 erase-start window, twice with a restart in between
    @(negedge clk); ecmd = 1;
    @(negedge clk); ecmd = 0;
    for (int i = 0; i < 3; i++) begin #1; check(dq3, 0, "R11"); @(negedge clk); end
    ecmd = 1;
    @(negedge clk); ecmd = 0;
    for (int i = 0; i < WIN; i++) begin #1; check(dq3, 0, "R11"); @(negedge clk); end
    #1; check(dq3, 1, "R11");
    @(negedge clk); #1; check(dq3, 1, "R11");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule